// File: doc/BRIEF.md
# Byte Permute Unit

The unit builds a 32-bit word by choosing four bytes out of an eight-byte pool made from two 32-bit operands. In the `lo` operand sit pool bytes 3..0, with byte 0 as its least significant byte. In the `hi` operand sit pool bytes 7..4. A 3-bit mode input picks how the choice is made.

In the generic mode, each destination byte has its own 4-bit control nibble. In that nibble, a 3-bit index picks a source byte and one more bit asks for sign fill. Six fixed modes derive all four indices from a 2-bit value alone. These give funnel windows forward and backward, a broadcast of one byte, clamped edge extensions to the left and right, and a broadcast of one 16-bit half.

Each operation passes through one registered stage with a valid/ready handshake. A new operation can be taken on every cycle as long as the consumer drains the output.

Top module: `byte_permute_unit`

## Requirements
- R1: Mode 0 (generic): destination byte d takes pool byte `selector[4d+2:4d]` unchanged when `selector[4d+3]` is 0. Pool bytes 3..0 come from `lo` and bytes 7..4 come from `hi`. With `hi` = 0, selector 0x0123 reverses the bytes of `lo`, and selector 0x2301 swaps the bytes inside each 16-bit half.
- R2: Mode 0: when `selector[4d+3]` is 1, every bit of destination byte d equals bit 7 of the chosen pool byte.
- R3: Mode 1 (forward funnel): for k = `selector[1:0]`, destination byte d is pool byte d+k.
- R4: Mode 2 (backward funnel): destination byte d is pool byte (k−d) mod 8. For k = 0 this gives destination bytes 3..0 = {5,6,7,0}.
- R5: Mode 3 (byte replicate): all four destination bytes equal pool byte k.
- R6: Mode 4 (left clamp): destination byte d is pool byte max(d,k). Mode 5 (right clamp): destination byte d is pool byte min(d,k).
- R7: Mode 6 (half replicate): the result is {lo[15:0], lo[15:0]} when `selector[0]` is 0 and {lo[31:16], lo[31:16]} when it is 1. `selector[1]` has no effect.
- R8: In modes 3 to 6 the value of `hi` has no effect on the result.
- R9: In modes 1 to 6, `selector[15:2]` has no effect on the result.
- R10: Mode 7 is reserved and yields a result of zero.
- R11: An operation is accepted when `in_valid` and `in_ready` are both high. `out_valid` is high in the cycle after acceptance. `in_ready` equals `!out_valid || out_ready`. After an output is taken with no new acceptance in that cycle, `out_valid` falls.
- R12: While `out_valid` is high and `out_ready` is low, `out_valid` and `result` hold their values.
- R13: When `rst_n` is low, `out_valid` is cleared and the unit is ready.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can take an operation |
| lo | input | 32 | Pool bytes 3..0 |
| hi | input | 32 | Pool bytes 7..4 |
| selector | input | 16 | Per-byte nibbles (mode 0) or 2-bit index in bits 1:0 |
| mode | input | 3 | Permute mode, 0..6, 7 reserved |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Consumer takes the result |
| result | output | 32 | Permuted word |

## Verification
The checker watches the handshake on every cycle. It covers acceptance leading to a valid output, draining, holding the output under back-pressure, and reset. It also checks the shape of the result in the cases that have one: the reserved mode gives zero, byte replicate gives four equal bytes, and half replicate gives two equal halves. The exact byte picked for each lane cannot be checked that way. That includes the funnel and clamp index patterns, sign fill, and the fact that `hi` and the upper selector bits are ignored. These are shown only by the bench, which compares each result against a table-driven model in directed and random scenarios.

// File: rtl/bpu_pkg.sv
package bpu_pkg;
  localparam int LANES     = 4;
  localparam int SRC_BYTES = 2 * LANES;
  localparam int IDX_W     = $clog2(SRC_BYTES);
  localparam int NIB_W     = IDX_W + 1;
  localparam int SEL_W     = LANES * NIB_W;
  localparam int KEY_W     = 2;

  typedef enum logic [2:0] {
    MODE_GENERIC = 3'd0,
    MODE_FWD     = 3'd1,
    MODE_BWD     = 3'd2,
    MODE_REP8    = 3'd3,
    MODE_CLAMP_L = 3'd4,
    MODE_CLAMP_R = 3'd5,
    MODE_REP16   = 3'd6,
    MODE_RSVD    = 3'd7
  } perm_mode_e;

  typedef struct packed {
    logic             sext;
    logic [IDX_W-1:0] src;
  } lane_sel_t;
endpackage

// File: rtl/bpu_pool.sv
module bpu_pool
  import bpu_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int WORD_W = LANES * BYTE_W
) (
  input  logic [WORD_W-1:0]   lo,
  input  logic [WORD_W-1:0]   hi,
  input  perm_mode_e          mode,
  output logic [2*WORD_W-1:0] pool
);
  logic lo_only;

  always_comb begin
    lo_only = (mode == MODE_REP8) || (mode == MODE_CLAMP_L) ||
              (mode == MODE_CLAMP_R) || (mode == MODE_REP16);
    pool = {(lo_only ? {WORD_W{1'b0}} : hi), lo};
  end
endmodule

// File: rtl/bpu_sel_gen.sv
module bpu_sel_gen
  import bpu_pkg::*;
(
  input  perm_mode_e            mode,
  input  logic [SEL_W-1:0]      selector,
  output lane_sel_t [LANES-1:0] lane_sel,
  output logic                  force_zero
);
  logic [IDX_W-1:0] key;

  assign key        = IDX_W'(selector[KEY_W-1:0]);
  assign force_zero = (mode == MODE_RSVD);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam logic [IDX_W-1:0] LANE_IDX = IDX_W'(l);

    always_comb begin
      lane_sel[l] = '0;
      unique case (mode)
        MODE_GENERIC: lane_sel[l] = lane_sel_t'(selector[l*NIB_W +: NIB_W]);
        MODE_FWD:     lane_sel[l].src = key + LANE_IDX;
        MODE_BWD:     lane_sel[l].src = key - LANE_IDX;
        MODE_REP8:    lane_sel[l].src = key;
        MODE_CLAMP_L: lane_sel[l].src = (LANE_IDX > key) ? LANE_IDX : key;
        MODE_CLAMP_R: lane_sel[l].src = (LANE_IDX < key) ? LANE_IDX : key;
        MODE_REP16:   lane_sel[l].src = {{(IDX_W-2){1'b0}}, key[0], LANE_IDX[0]};
        default:      lane_sel[l] = '0;
      endcase
    end
  end
endmodule

// File: rtl/bpu_lane_mux.sv
module bpu_lane_mux
  import bpu_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int POOL_W = SRC_BYTES * BYTE_W
) (
  input  logic [POOL_W-1:0] pool,
  input  lane_sel_t         sel,
  output logic [BYTE_W-1:0] lane_byte
);
  logic [BYTE_W-1:0] picked;

  always_comb begin
    picked    = pool[sel.src*BYTE_W +: BYTE_W];
    lane_byte = sel.sext ? {BYTE_W{picked[BYTE_W-1]}} : picked;
  end
endmodule

// File: rtl/byte_permute_unit.sv
module byte_permute_unit
  import bpu_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int WORD_W = LANES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] lo,
  input  logic [WORD_W-1:0] hi,
  input  logic [SEL_W-1:0]  selector,
  input  logic [2:0]        mode,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] result
);
  perm_mode_e            mode_e;
  logic [2*WORD_W-1:0]   pool;
  lane_sel_t [LANES-1:0] lane_sel;
  logic                  force_zero;
  logic [WORD_W-1:0]     lanes_word;
  logic [WORD_W-1:0]     perm_word;
  logic                  accept;
  logic                  valid_d, valid_q;
  logic [WORD_W-1:0]     data_q;

  assign mode_e = perm_mode_e'(mode);

  bpu_pool #(.BYTE_W(BYTE_W)) u_pool (
    .lo   (lo),
    .hi   (hi),
    .mode (mode_e),
    .pool (pool)
  );

  bpu_sel_gen u_sel (
    .mode       (mode_e),
    .selector   (selector),
    .lane_sel   (lane_sel),
    .force_zero (force_zero)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_mux
    bpu_lane_mux #(.BYTE_W(BYTE_W)) u_mux (
      .pool      (pool),
      .sel       (lane_sel[l]),
      .lane_byte (lanes_word[l*BYTE_W +: BYTE_W])
    );
  end

  assign perm_word = force_zero ? '0 : lanes_word;

  // handshake: one-entry output stage
  assign in_ready = !valid_q || out_ready;
  assign accept   = in_valid && in_ready;

  always_comb begin
    valid_d = valid_q;
    if (accept) begin
      valid_d = 1'b1;
    end else if (out_ready) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      data_q <= perm_word;
    end
  end

  assign out_valid = valid_q;
  assign result    = data_q;
endmodule

// File: rtl/bpu_checker.sv
module bpu_checker #(
  parameter int BYTE_W = 8,
  localparam int WORD_W = 4 * BYTE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [2:0]        mode,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] result
);
  logic acc;
  assign acc = in_valid && in_ready;

  assert_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  assert_drain_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(result)));

  assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && mode == 3'd7) |=> (result == '0));

  assert_rep8_equal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && mode == 3'd3) |=>
      (result[BYTE_W-1:0] == result[2*BYTE_W-1:BYTE_W] &&
       result[BYTE_W-1:0] == result[3*BYTE_W-1:2*BYTE_W] &&
       result[BYTE_W-1:0] == result[4*BYTE_W-1:3*BYTE_W]));

  assert_rep16_halves_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && mode == 3'd6) |=> (result[2*BYTE_W-1:0] == result[4*BYTE_W-1:2*BYTE_W]));

  assert_reset_clear_R13: assert property (@(posedge clk)
    !rst_n |=> !out_valid);
endmodule

bind byte_permute_unit bpu_checker #(.BYTE_W(BYTE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .mode      (mode),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .result    (result)
);

// File: tb/byte_permute_unit_tb.sv
`timescale 1ns/1ps
module byte_permute_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] lo, hi;
  logic [15:0] selector;
  logic [2:0]  mode;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] result;

  int          n_cmp = 0;
  int          n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  string       cur_tag = "";
  bit          running = 0;
  bit          bp_en = 0;
  bit          stall = 0;

  always #10 clk = ~clk;

  byte_permute_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .lo(lo), .hi(hi), .selector(selector), .mode(mode),
    .out_valid(out_valid), .out_ready(out_ready), .result(result)
  );

  // index pattern, destination byte 3 in the top nibble
  function automatic logic [15:0] fixed_pat(input logic [2:0] m, input logic [1:0] k);
    case (m)
      3'd1: case (k) 0: return 16'h3210; 1: return 16'h4321; 2: return 16'h5432; default: return 16'h6543; endcase
      3'd2: case (k) 0: return 16'h5670; 1: return 16'h6701; 2: return 16'h7012; default: return 16'h0123; endcase
      3'd3: case (k) 0: return 16'h0000; 1: return 16'h1111; 2: return 16'h2222; default: return 16'h3333; endcase
      3'd4: case (k) 0: return 16'h3210; 1: return 16'h3211; 2: return 16'h3222; default: return 16'h3333; endcase
      3'd5: case (k) 0: return 16'h0000; 1: return 16'h1110; 2: return 16'h2210; default: return 16'h3210; endcase
      default: return k[0] ? 16'h3232 : 16'h1010;
    endcase
  endfunction

  function automatic logic [31:0] ref_perm(input logic [31:0] l, input logic [31:0] h,
                                            input logic [15:0] s, input logic [2:0] m);
    logic [63:0] p;
    logic [15:0] pat;
    logic [31:0] r;
    if (m == 3'd7) return 32'h0;
    p = {h, l};
    if (m >= 3'd3) p[63:32] = 32'h0;
    pat = (m == 3'd0) ? s : fixed_pat(m, s[1:0]);
    r = 32'h0;
    for (int d = 0; d < 4; d++) begin
      logic [3:0] nib;
      logic [7:0] b;
      nib = pat[4*d +: 4];
      b = p[8*nib[2:0] +: 8];
      if (nib[3]) b = {8{b[7]}};
      r[8*d +: 8] = b;
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(negedge clk) out_ready <= stall ? 1'b0 : (bp_en ? 1'($urandom % 2) : 1'b1);

  // cycle-by-cycle model comparison, 5 ns after the falling edge
  always begin
    @(negedge clk);
    #5;
    if (running) begin
      chk("R11 in_ready", 32'(in_ready), 32'(!out_valid || out_ready));
      chk("R11 out_valid", 32'(out_valid), 32'(exp_q.size() > 0));
      if (out_valid && exp_q.size() > 0) begin
        chk(tag_q[0], result, exp_q[0]);
        if (out_ready) begin
          void'(exp_q.pop_front());
          void'(tag_q.pop_front());
        end
      end
      if (in_valid && in_ready) begin
        exp_q.push_back(ref_perm(lo, hi, selector, mode));
        tag_q.push_back(cur_tag);
      end
    end
  end

  // called at a falling edge, returns at a falling edge
  task automatic send(input logic [31:0] l, input logic [31:0] h, input logic [15:0] s,
                      input logic [2:0] m, input string tag);
    bit acc;
    in_valid = 1'b1; lo = l; hi = h; selector = s; mode = m; cur_tag = tag;
    forever begin
      #5 acc = in_ready;
      @(negedge clk);
      if (acc) break;
    end
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; lo = '0; hi = '0; selector = '0; mode = '0;
    repeat (3) @(negedge clk);
    #5;
    chk("R13 out_valid in reset", 32'(out_valid), 32'h0);
    chk("R13 in_ready in reset", 32'(in_ready), 32'h1);
    @(negedge clk);
    rst_n = 1'b1;
    running = 1;
    @(negedge clk);

    send(32'h44332211, 32'h88776655, 16'h3210, 3'd0, "R1 identity");
    send(32'h44332211, 32'h88776655, 16'h7654, 3'd0, "R1 hi bytes");
    send(32'h44332211, 32'h0, 16'h0123, 3'd0, "R1 byte reverse");
    send(32'h44332211, 32'h0, 16'h2301, 3'd0, "R1 half swap");
    send(32'h7F80017E, 32'hC0FF0040, 16'h8899, 3'd0, "R2 sign fill");
    send(32'h7F80017E, 32'hC0FF0040, 16'hCDEF, 3'd0, "R2 sign fill hi");
    for (int k = 0; k < 4; k++) begin
      logic [15:0] s;
      s = {14'($urandom), 2'(k)};
      send(32'hA3A2A1A0, 32'hB7B6B5B4, s, 3'd1, "R3 R9 forward funnel");
      send(32'hA3A2A1A0, 32'hB7B6B5B4, s, 3'd2, "R4 R9 backward funnel");
      send(32'hA3A2A1A0, 32'hB7B6B5B4, s, 3'd3, "R5 R8 byte replicate");
      send(32'hA3A2A1A0, 32'hB7B6B5B4, s, 3'd4, "R6 R8 left clamp");
      send(32'hA3A2A1A0, 32'hB7B6B5B4, s, 3'd5, "R6 R8 right clamp");
      send(32'hA3A2A1A0, 32'hFFFFFFFF, s, 3'd6, "R7 R8 half replicate");
    end
    send(32'h12345678, 32'h9ABCDEF0, 16'hFFFE, 3'd6, "R7 bit1 ignored");
    send(32'h12345678, 32'h9ABCDEF0, 16'h0123, 3'd7, "R10 reserved zero");
    idle(2);

    stall = 1;
    send(32'hDEADBEEF, 32'h0, 16'h0123, 3'd0, "R12 held result");
    in_valid = 1'b1; lo = 32'h55555555; cur_tag = "R12 blocked input";
    repeat (4) @(negedge clk);
    stall = 0;
    send(32'h55555555, 32'h0, 16'h3210, 3'd0, "R12 after release");

    bp_en = 1;
    for (int i = 0; i < 300; i++)
      send($urandom, $urandom, 16'($urandom), 3'($urandom % 8), "R11 random stream");
    idle(4);
    bp_en = 0;

    stall = 1;
    send(32'h01020304, 32'h0, 16'h3210, 3'd0, "R13 pending");
    idle(1);
    running = 0;
    rst_n = 1'b0;
    #5;
    chk("R13 out_valid after reset", 32'(out_valid), 32'h0);
    exp_q.delete(); tag_q.delete();
    @(negedge clk);
    rst_n = 1'b1;
    stall = 0;
    @(negedge clk);
    running = 1;
    send(32'hCAFEF00D, 32'h0, 16'h0123, 3'd0, "R13 resume");
    idle(3);
    summary();
  end
endmodule